// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is a single-direction DMA engine. It pulls a block of bytes out of a word-wide memory read port and delivers them as one packet on an AXI4-Stream master port. Software drives it through a small register window. It enables the channel with a run bit, writes a word-aligned source address, and then writes a byte count. A nonzero byte count launches the packet.

Each beat carries one memory word. All beats except the last have every byte lane valid. The final beat carries TLAST, and its TKEEP has ones only in the low-order lanes that still hold payload. A start address that is not a whole number of bus words is not realigned. Instead it raises an error flag and halts the channel.

Completion and error are latched status flags, and each is cleared by writing a one to it. The interrupt line combines the latched flags with their enable bits. A self-clearing soft-reset bit returns the channel to a clean idle state from any condition, including a packet in flight.

Top module: `mm2s_dma`

## Requirements
- R1: After reset the channel is idle: m_tvalid, mem_rd_en and irq are 0, the status register (offset 0x04) reads 0x1, and the control register (offset 0x00) reads 0.
- R2: A write to the length register (offset 0x28) launches a transfer only if all of these hold: the value is nonzero, the channel is idle, and the run bit (control bit 0) is 1. A zero length, or any length written while run is 0, produces no beat, and status bit 0 (idle) stays 1.
- R3: A transfer of L bytes from byte address A sends exactly ceil(L/BYTES) beats. Beat k carries the memory word at byte address A + k*BYTES. TLAST is 1 on the final beat only, and TVALID drops in the cycle after that beat's handshake.
- R4: If the source address register (offset 0x18) holds an address that is not a multiple of BYTES when a launch is attempted, no beat is sent, status bit 5 (error) is set and the run bit clears. The memory read address is always a multiple of BYTES.
- R5: TKEEP is all ones on every beat except the last. On the last beat, TKEEP has the low (L mod BYTES) bits set, or all bits set when that remainder is 0.
- R6: While TVALID is 1 and TREADY is 0, TVALID, TDATA, TKEEP and TLAST hold their values, and no memory read is issued while TVALID is 1.
- R7: While a transfer runs, status bit 0 reads 0. Writes to the length or source register during that time are ignored: the packet keeps its length and the register reads back the old value.
- R8: Status bit 4 (complete) sets on the final handshake. Writing a 1 to status bit 4 or bit 5 clears that bit, and writing a 0 leaves it unchanged.
- R9: irq is 1 exactly when (status bit 4 and control bit 4) or (status bit 5 and control bit 5).
- R10: Writing a 1 to control bit 1 starts a soft reset. Bit 1 reads 1 for one cycle and then 0. After that cycle the channel is idle, the control register reads 0, the status register reads 0x1, and any packet in flight is abandoned.
- R11: The length register keeps only its low LEN_W bits (14 by default). Write bits above these are dropped, so 0x4000 starts nothing and 0x4005 moves 5 bytes. The largest transfer, 16383 bytes, sends 4096 beats with a final TKEEP of 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_rd_en | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_rd_addr | output | ADDR_W | Byte address of the word to read |
| mem_rd_data | input | DATA_W | Memory read data, valid one cycle after mem_rd_en |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | DATA_W/8 | Stream byte-valid mask |
| m_tlast | output | 1 | Final beat of the packet |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the memory returns data on the cycle after the read strobe. They also assume that the only way a beat may be withdrawn before its handshake is a write that sets the soft-reset bit. The stability property therefore excludes that cycle and the one after it.

The bench keeps within these assumptions. Its memory model answers every read with exactly one cycle of latency. It never aborts a packet other than through the soft-reset bit, and it holds TREADY high in that test. Elsewhere TREADY is random, so it covers long stalls as well as back-to-back acceptance.

// File: rtl/mm2s_dma.sv
module mm2s_dma #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [DATA_W-1:0] m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              irq
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(8'h04);
  localparam logic [REG_AW-1:0] A_SRC  = REG_AW'(8'h18);
  localparam logic [REG_AW-1:0] A_LEN  = REG_AW'(8'h28);
  localparam logic [LEN_W:0]    PAD    = (LEN_W+1)'(BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_SEND} st_t;

  st_t               st;
  logic              run, srst, ioc_en, err_en, ioc, err;
  logic [ADDR_W-1:0] src_q, ptr;
  logic [LEN_W-1:0]  len_q, left;
  logic [BYTES-1:0]  tail_keep, tk;
  logic [DATA_W-1:0] dat_q;

  wire              wr_ctrl   = reg_we && reg_addr == A_CTRL;
  wire              wr_stat   = reg_we && reg_addr == A_STAT;
  wire              wr_src    = reg_we && reg_addr == A_SRC;
  wire              wr_len    = reg_we && reg_addr == A_LEN;
  wire [LEN_W-1:0]  wlen      = reg_wdata[LEN_W-1:0];
  wire              idle      = st == S_IDLE;
  wire              launch    = wr_len && idle && run && wlen != '0;
  wire              misal     = |src_q[OFF_W-1:0];
  wire              last_beat = left == LEN_W'(1);
  wire [LEN_W:0]    nbeat     = ({1'b0, wlen} + PAD) >> OFF_W;
  wire [OFF_W-1:0]  rem       = wlen[OFF_W-1:0];

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      tk[i] = (rem == '0) || (OFF_W'(i) < rem);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st        <= S_IDLE;
      run       <= 1'b0;
      srst      <= 1'b0;
      ioc_en    <= 1'b0;
      err_en    <= 1'b0;
      ioc       <= 1'b0;
      err       <= 1'b0;
      src_q     <= '0;
      len_q     <= '0;
      ptr       <= '0;
      left      <= '0;
      tail_keep <= '0;
      dat_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        run    <= reg_wdata[0];
        srst   <= reg_wdata[1];
        ioc_en <= reg_wdata[4];
        err_en <= reg_wdata[5];
      end
      if (wr_stat) begin
        if (reg_wdata[4]) ioc <= 1'b0;
        if (reg_wdata[5]) err <= 1'b0;
      end
      if (wr_src && idle) src_q <= reg_wdata[ADDR_W-1:0];
      if (wr_len && idle) len_q <= wlen;
      if (launch) begin
        if (misal) begin
          err <= 1'b1;
          run <= 1'b0;
        end else begin
          st        <= S_REQ;
          ptr       <= src_q;
          left      <= nbeat[LEN_W-1:0];
          tail_keep <= tk;
        end
      end
      case (st)
        S_REQ:  st <= S_WAIT;
        S_WAIT: begin
          dat_q <= mem_rd_data;
          st    <= S_SEND;
        end
        S_SEND: if (m_tready) begin
          if (last_beat) begin
            st  <= S_IDLE;
            ioc <= 1'b1;
          end else begin
            st   <= S_REQ;
            left <= left - LEN_W'(1);
            ptr  <= ptr + ADDR_W'(BYTES);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {26'd0, err_en, ioc_en, 2'd0, srst, run};
      A_STAT:  reg_rdata = {26'd0, err, ioc, 3'd0, idle};
      A_SRC:   reg_rdata = 32'(src_q);
      A_LEN:   reg_rdata = 32'(len_q);
      default: reg_rdata = '0;
    endcase
  end

  assign mem_rd_en   = st == S_REQ;
  assign mem_rd_addr = ptr;
  assign m_tvalid    = st == S_SEND;
  assign m_tdata     = dat_q;
  assign m_tlast     = m_tvalid && last_beat;
  assign m_tkeep     = !m_tvalid ? '0 : (last_beat ? tail_keep : '1);
  assign irq         = (ioc && ioc_en) || (err && err_en);
endmodule

// File: rtl/mm2s_dma_props.sv
module mm2s_dma_props #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_wr,
  input logic              mem_rd_en,
  input logic [OFF_W-1:0]  rd_lo,
  input logic [DATA_W-1:0] m_tdata,
  input logic [DATA_W/8-1:0] m_tkeep,
  input logic              m_tlast,
  input logic              m_tvalid,
  input logic              m_tready
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && !sr_wr && !$past(sr_wr)) |=>
      (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));

  p_no_read_in_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !mem_rd_en);

  p_aligned_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> rd_lo == '0);

  p_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> &m_tkeep);

  p_keep_low_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tkeep[0]);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);
endmodule

bind mm2s_dma mm2s_dma_props #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .sr_wr     (reg_we && reg_addr == '0 && reg_wdata[1]),
  .mem_rd_en (mem_rd_en),
  .rd_lo     (mem_rd_addr[OFF_W-1:0]),
  .m_tdata   (m_tdata),
  .m_tkeep   (m_tkeep),
  .m_tlast   (m_tlast),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready)
);

// File: tb/mm2s_dma_test.sv
`timescale 1ns/1ps
module mm2s_dma_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr, mem_rd_data = 0;
  logic [31:0] m_tdata;
  logic [3:0]  m_tkeep;
  logic        m_tlast, m_tvalid, irq;
  logic        m_tready = 0;

  int n_vec = 0, n_bad = 0;
  logic [31:0] e_addr = 0;
  int e_nb = 0, e_len = 0, got = 0;
  bit chk_on = 0, rnd_ready = 0;
  bit stall = 0;
  logic [31:0] p_dat;
  logic [3:0]  p_keep;
  logic        p_last;

  mm2s_dma uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, a[23:8] + 16'h1357};
  endfunction

  function automatic logic [3:0] tailk(input int len);
    int r = len % 4;
    return (r == 0) ? 4'hF : (4'hF >> (4 - r));
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (stall)
      chk("R6 held beat", {m_tvalid, m_tlast, m_tkeep, m_tdata[25:0]},
          {1'b1, p_last, p_keep, p_dat[25:0]});
    m_tready = rnd_ready ? ($urandom_range(0, 99) < 65) : 1'b1;
    if (m_tvalid && m_tready && chk_on) begin
      if (got >= e_nb) chk("R3 extra beat", 32'(got), 32'(e_nb - 1));
      else begin
        chk("R3 beat data", m_tdata, memf(e_addr + 32'(4 * got)));
        chk("R5 beat keep", 32'(m_tkeep), 32'((got == e_nb - 1) ? tailk(e_len) : 4'hF));
        chk("R3 beat last", 32'(m_tlast), 32'(got == e_nb - 1));
      end
      got++;
    end
    stall  = m_tvalid && !m_tready;
    p_dat  = m_tdata;
    p_keep = m_tkeep;
    p_last = m_tlast;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(8'h04, s);
      if (s[0] && s[4]) return;
    end
    chk(tag, 32'h0, 32'h1);
  endtask

  task automatic arm(input logic [31:0] a, input int len, input logic [31:0] wval);
    e_addr = a; e_len = len; e_nb = (len + 3) / 4; got = 0; chk_on = 1;
    wr(8'h18, a);
    wr(8'h28, wval);
  endtask

  task automatic xfer(input logic [31:0] a, input int len, input bit clr);
    arm(a, len, 32'(len));
    wait_done("R8 completion");
    repeat (2) @(negedge clk);
    chk("R3 beat count", 32'(got), 32'(e_nb));
    if (clr) wr(8'h04, 32'h10);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tvalid", 32'(m_tvalid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rd_en", 32'(mem_rd_en), 0);
    rd(8'h04, v); chk("R1 status", v, 32'h1);
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);

    wr(8'h00, 32'h31);
    e_nb = 0; got = 0; chk_on = 1;
    wr(8'h28, 0);
    repeat (10) @(negedge clk);
    rd(8'h04, v); chk("R2 zero length idle", v, 32'h1);
    chk("R2 zero length no beat", 32'(got), 0);
    wr(8'h00, 32'h30);
    wr(8'h28, 8);
    repeat (10) @(negedge clk);
    rd(8'h04, v); chk("R2 run off idle", v, 32'h1);
    chk("R2 run off no beat", 32'(got), 0);
    wr(8'h00, 32'h31);

    xfer(32'h100, 256, 0);
    chk("R9 irq on complete", 32'(irq), 1);
    wr(8'h04, 32'h00);
    rd(8'h04, v); chk("R8 write zero keeps flag", v, 32'h11);
    wr(8'h04, 32'h10);
    rd(8'h04, v); chk("R8 W1C complete", v, 32'h1);
    chk("R9 irq cleared", 32'(irq), 0);

    xfer(32'h200, 255, 1);
    xfer(32'h400, 253, 1);
    xfer(32'h600, 1, 1);
    xfer(32'h700, 6, 1);

    wr(8'h00, 32'h21);
    xfer(32'h800, 12, 0);
    rd(8'h04, v); chk("R8 flag set", v, 32'h11);
    chk("R9 irq masked", 32'(irq), 0);
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h31);

    rnd_ready = 1;
    arm(32'h300, 64, 64);
    repeat (6) @(negedge clk);
    rd(8'h04, v); chk("R7 busy status", v, 32'h0);
    wr(8'h28, 8);
    wr(8'h18, 32'h900);
    rd(8'h28, v); chk("R7 length kept", v, 64);
    rd(8'h18, v); chk("R7 source kept", v, 32'h300);
    wait_done("R7 completion");
    repeat (2) @(negedge clk);
    chk("R7 beat count", 32'(got), 16);
    wr(8'h04, 32'h10);

    e_nb = 0; got = 0; chk_on = 1;
    wr(8'h18, 32'h102);
    wr(8'h28, 16);
    repeat (10) @(negedge clk);
    rd(8'h04, v); chk("R4 error flag", v, 32'h21);
    rd(8'h00, v); chk("R4 run cleared", v, 32'h30);
    chk("R4 no beat", 32'(got), 0);
    chk("R9 irq on error", 32'(irq), 1);
    wr(8'h04, 32'h20);
    rd(8'h04, v); chk("R8 W1C error", v, 32'h1);
    chk("R9 irq after error clear", 32'(irq), 0);
    wr(8'h00, 32'h31);

    e_nb = 0; got = 0;
    wr(8'h28, 32'h4000);
    repeat (10) @(negedge clk);
    rd(8'h28, v); chk("R11 truncated length", v, 0);
    chk("R11 truncated no beat", 32'(got), 0);
    arm(32'hA00, 5, 32'h4005);
    wait_done("R11 completion");
    repeat (2) @(negedge clk);
    chk("R11 truncated beat count", 32'(got), 2);
    wr(8'h04, 32'h10);

    for (int t = 0; t < 24; t++)
      xfer({16'h0, 14'($urandom_range(0, 16383)), 2'b00}, $urandom_range(1, 300), 1);

    xfer(32'h10000, 16383, 1);

    rnd_ready = 0;
    xfer(32'hB00, 8, 0);
    chk_on = 0;
    wr(8'h18, 32'hC00);
    wr(8'h28, 400);
    repeat (20) @(negedge clk);
    wr(8'h00, 32'h02);
    rd_now(8'h00, v); chk("R10 reset bit visible", v, 32'h2);
    @(negedge clk);
    rd_now(8'h00, v); chk("R10 ctrl cleared", v, 32'h0);
    rd_now(8'h04, v); chk("R10 status cleared", v, 32'h1);
    chk("R10 packet abandoned", 32'(m_tvalid), 0);
    chk("R10 irq low", 32'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R10 stays idle", 32'(m_tvalid || mem_rd_en), 0);

    wr(8'h00, 32'h31);
    xfer(32'hD00, 40, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule